// File: doc/BRIEF.md
# MESI Snooping Cache-Line Controller

This block keeps the coherence state of every line in a small direct-mapped private cache that sits on a shared snooping bus. Each line is in one of four states: invalid, shared, exclusive-clean or modified. The controller takes load and store requests from its processor. It raises bus requests for fills, ownership, upgrades and victim writebacks. It also watches the transactions that other caches place on the bus. For those it answers through a wired-OR shared signal and a flush strobe, and it updates or drops its own copies to match.

A bus transaction lasts one cycle. It takes place in the cycle where `bus_req` and `bus_gnt` are both high, and its effect on the line state lands on the following clock edge. In that same granted cycle the controller samples the shared line. Processor requests use a valid/ready handshake, and `cpu_ready` rises in the cycle the request completes. A snooped transaction is handled in the cycle it is presented. While it is present, all local activity waits.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is invalid, so the first access to any address misses. With idle inputs, `cpu_ready`, `bus_req`, `shared_out` and `flush_out` are all low. Bus and snoop command codes are: 0 read, 1 read-for-ownership, 2 upgrade, 3 writeback.
- R2: A read miss requests command 0 at the request address. If `shared_in` is low in the granted cycle the line fills as exclusive-clean. If it is high the line fills as shared.
- R3: `shared_out` is high only in a cycle where a snooped command 0 hits a valid copy (tag match and state not invalid).
- R4: A write that hits an exclusive-clean or modified line completes in the same cycle with no bus request, and the line becomes modified.
- R5: A write that hits a shared line requests command 2 at the request address, without a data fetch. On grant it completes and the line becomes modified.
- R6: A write miss requests command 1 at the request address. On grant the line is installed as modified.
- R7: On a miss where the indexed slot holds a modified line with another tag, the controller first requests command 3 at the victim's address ({victim tag, index}) and only then the fill. A clean victim is dropped without any bus traffic.
- R8: A snooped command 1 or 2 that hits makes the copy invalid. `flush_out` pulses only when the copy was modified and the command is 1.
- R9: A snooped command 0 that hits turns a modified copy into shared and pulses `flush_out`. An exclusive-clean copy becomes shared with no flush, and a shared copy stays shared.
- R10: While a request needs the bus and `bus_gnt` is low, `bus_req` stays high with a stable command and `cpu_ready` stays low. `cpu_ready` rises in the granted cycle of the request's last transaction.
- R11: In any cycle with `snp_valid` high, `bus_req` and `cpu_ready` are low, whatever the processor presents.
- R12: A read hit in any valid state completes in the same cycle without a bus request. A snooped command 3, or a snoop whose tag misses, changes no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Line address: upper TAG_W bits are the tag, lower INDEX_W the index |
| cpu_ready | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus transaction wanted |
| bus_cmd | output | 2 | Command of the wanted transaction |
| bus_addr | output | ADDR_W | Address of the wanted transaction |
| bus_gnt | input | 1 | Transaction takes place this cycle |
| shared_in | input | 1 | Wired-OR shared line, sampled in the granted cycle |
| snp_valid | input | 1 | A transaction from another cache is on the bus |
| snp_cmd | input | 2 | Snooped command |
| snp_addr | input | ADDR_W | Snooped line address |
| shared_out | output | 1 | This cache holds a copy of the snooped line being read |
| flush_out | output | 1 | This cache must place its dirty data on the bus |

## Verification
The assertions assume that a processor request holds its address and direction until `cpu_ready`. They also assume that `bus_gnt` only has meaning while `bus_req` is high, and that `shared_in` only has meaning in a granted cycle. The stimulus keeps to these rules. It drives every input half a cycle away from the active edge, raises the grant only after `bus_req` is seen, and clears grant and shared line right after each granted cycle. Snoops are driven with and without a pending processor request. This covers the priority rule and does not require the environment to avoid collisions.

// File: rtl/mesi_pkg.sv
// Shared types for the coherence controller: line states and bus command codes.
// The command encoding is visible on the ports and must not be reordered.
package mesi_pkg;
    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_SHR = 2'd1,
        ST_EXC = 2'd2,
        ST_MOD = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        CMD_RD   = 2'd0,
        CMD_RDX  = 2'd1,
        CMD_UPGR = 2'd2,
        CMD_WB   = 2'd3
    } bus_cmd_t;
endpackage

// File: rtl/mesi_tag_store.sv
// Direct-mapped tag and state storage. It has two combinational read ports
// (processor side and snoop side) and one write port.
// Assumes the caller merges all updates into the single write port.
// Line states reset to invalid. Tags are left unreset because an invalid
// state masks them.
module mesi_tag_store
    import mesi_pkg::*;
#(
    parameter int INDEX_W = 2,
    parameter int TAG_W   = 6,
    localparam int LINES  = 1 << INDEX_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [INDEX_W-1:0]     ra_idx,
    output logic [TAG_W-1:0]       ra_tag,
    output line_st_t               ra_st,
    input  logic [INDEX_W-1:0]     rb_idx,
    output logic [TAG_W-1:0]       rb_tag,
    output line_st_t               rb_st,
    input  logic                   we,
    input  logic [INDEX_W-1:0]     w_idx,
    input  logic [TAG_W-1:0]       w_tag,
    input  line_st_t               w_st,
    output logic [LINES-1:0][1:0]  st_all
);
    logic [TAG_W-1:0] tag_q [LINES];
    line_st_t         st_q  [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // State register of one line: reset to invalid, else take the write port.
        always_ff @(posedge clk) begin
            if (!rst_n)
                st_q[g] <= ST_INV;
            else if (we && (w_idx == INDEX_W'(g)))
                st_q[g] <= w_st;
        end

        // Tag register of one line: loaded whenever its slot is written.
        always_ff @(posedge clk) begin
            if (we && (w_idx == INDEX_W'(g)))
                tag_q[g] <= w_tag;
        end

        assign st_all[g] = st_q[g];
    end

    // Read ports: plain indexed lookups.
    always_comb begin
        ra_tag = tag_q[ra_idx];
        ra_st  = st_q[ra_idx];
        rb_tag = tag_q[rb_idx];
        rb_st  = st_q[rb_idx];
    end
endmodule

// File: rtl/mesi_snoop_unit.sv
// Response to a transaction observed from another cache. It decides the new
// state of a hit copy, the shared-line answer and the flush strobe.
// Assumes one snooped transaction per cycle; writebacks need no response.
module mesi_snoop_unit
    import mesi_pkg::*;
(
    input  logic     snp_valid,
    input  bus_cmd_t snp_cmd,
    input  logic     tag_match,
    input  line_st_t cur_st,
    output logic     upd,
    output line_st_t nxt_st,
    output logic     shared_out,
    output logic     flush
);
    logic hit;

    // Snoop decision: downgrade on read, drop on ownership or upgrade.
    always_comb begin
        hit        = snp_valid && tag_match && (cur_st != ST_INV);
        upd        = 1'b0;
        nxt_st     = cur_st;
        shared_out = 1'b0;
        flush      = 1'b0;
        if (hit) begin
            unique case (snp_cmd)
                CMD_RD: begin
                    shared_out = 1'b1;
                    flush      = (cur_st == ST_MOD);
                    if (cur_st != ST_SHR) begin
                        upd    = 1'b1;
                        nxt_st = ST_SHR;
                    end
                end
                CMD_RDX: begin
                    upd    = 1'b1;
                    nxt_st = ST_INV;
                    flush  = (cur_st == ST_MOD);
                end
                CMD_UPGR: begin
                    upd    = 1'b1;
                    nxt_st = ST_INV;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mesi_req_unit.sv
// Processor-side sequencing. It classifies the request as hit, upgrade,
// victim writeback or fill, and raises the matching bus request.
// It commits the line update in the granted cycle.
// Assumes single-cycle bus transactions and a request held until ready.
module mesi_req_unit
    import mesi_pkg::*;
#(
    parameter int INDEX_W = 2,
    parameter int TAG_W   = 6,
    localparam int ADDR_W = INDEX_W + TAG_W
) (
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              blocked,
    input  line_st_t          cur_st,
    input  logic [TAG_W-1:0]  cur_tag,
    input  logic              bus_gnt,
    input  logic              shared_in,
    output logic              cpu_ready,
    output logic              bus_req,
    output bus_cmd_t          bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              upd,
    output line_st_t          nxt_st,
    output logic [TAG_W-1:0]  nxt_tag
);
    logic [TAG_W-1:0]   req_tag;
    logic [INDEX_W-1:0] req_idx;
    logic               present;
    logic               hit;

    // Request classification and the transaction it needs.
    always_comb begin
        req_tag   = cpu_addr[ADDR_W-1:INDEX_W];
        req_idx   = cpu_addr[INDEX_W-1:0];
        present   = (cur_st != ST_INV);
        hit       = present && (cur_tag == req_tag);
        cpu_ready = 1'b0;
        bus_req   = 1'b0;
        bus_cmd   = CMD_RD;
        bus_addr  = cpu_addr;
        upd       = 1'b0;
        nxt_st    = cur_st;
        nxt_tag   = cur_tag;
        if (cpu_valid && !blocked) begin
            if (hit) begin
                if (!cpu_write || cur_st == ST_MOD) begin
                    cpu_ready = 1'b1;
                end else if (cur_st == ST_EXC) begin
                    cpu_ready = 1'b1;
                    upd       = 1'b1;
                    nxt_st    = ST_MOD;
                end else begin
                    bus_req = 1'b1;
                    bus_cmd = CMD_UPGR;
                    if (bus_gnt) begin
                        cpu_ready = 1'b1;
                        upd       = 1'b1;
                        nxt_st    = ST_MOD;
                    end
                end
            end else if (cur_st == ST_MOD) begin
                bus_req  = 1'b1;
                bus_cmd  = CMD_WB;
                bus_addr = {cur_tag, req_idx};
                if (bus_gnt) begin
                    upd    = 1'b1;
                    nxt_st = ST_INV;
                end
            end else begin
                bus_req = 1'b1;
                bus_cmd = cpu_write ? CMD_RDX : CMD_RD;
                if (bus_gnt) begin
                    cpu_ready = 1'b1;
                    upd       = 1'b1;
                    nxt_tag   = req_tag;
                    nxt_st    = cpu_write ? ST_MOD : (shared_in ? ST_SHR : ST_EXC);
                end
            end
        end
    end
endmodule

// File: rtl/mesi_line_ctrl.sv
// Top of the per-line coherence controller. It joins the tag store, the
// snoop responder and the request sequencer, and merges their updates into
// one write port. A snoop present in a cycle blocks the local request, so
// the two never write in the same cycle.
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int INDEX_W = 2,
    parameter int TAG_W   = 6,
    localparam int ADDR_W = INDEX_W + TAG_W,
    localparam int LINES  = 1 << INDEX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_gnt,
    input  logic              shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              shared_out,
    output logic              flush_out
);
    logic [INDEX_W-1:0]    c_idx, s_idx;
    logic [TAG_W-1:0]      c_tag, s_tag;
    line_st_t              c_st, s_st;
    logic [LINES-1:0][1:0] st_all;
    logic                  s_upd, r_upd;
    line_st_t              s_nxt, r_nxt;
    logic [TAG_W-1:0]      r_tag;
    bus_cmd_t              r_cmd;
    logic                  we;
    logic [INDEX_W-1:0]    w_idx;
    logic [TAG_W-1:0]      w_tag;
    line_st_t              w_st;

    assign c_idx = cpu_addr[INDEX_W-1:0];
    assign s_idx = snp_addr[INDEX_W-1:0];

    mesi_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(c_idx), .ra_tag(c_tag), .ra_st(c_st),
        .rb_idx(s_idx), .rb_tag(s_tag), .rb_st(s_st),
        .we(we), .w_idx(w_idx), .w_tag(w_tag), .w_st(w_st),
        .st_all(st_all)
    );

    mesi_snoop_unit u_snoop (
        .snp_valid(snp_valid), .snp_cmd(bus_cmd_t'(snp_cmd)),
        .tag_match(s_tag == snp_addr[ADDR_W-1:INDEX_W]), .cur_st(s_st),
        .upd(s_upd), .nxt_st(s_nxt), .shared_out(shared_out), .flush(flush_out)
    );

    mesi_req_unit #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_req (
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .blocked(snp_valid), .cur_st(c_st), .cur_tag(c_tag),
        .bus_gnt(bus_gnt), .shared_in(shared_in),
        .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_cmd(r_cmd), .bus_addr(bus_addr),
        .upd(r_upd), .nxt_st(r_nxt), .nxt_tag(r_tag)
    );

    assign bus_cmd = r_cmd;

    // Write-port merge: a snoop update wins; the local side is blocked anyway.
    always_comb begin
        we    = s_upd || r_upd;
        w_idx = s_upd ? s_idx : c_idx;
        w_tag = s_upd ? s_tag : r_tag;
        w_st  = s_upd ? s_nxt : r_nxt;
    end

    AST_RD_FILL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && !snp_valid && bus_cmd == CMD_RD) |=>
        (line_st_t'(st_all[$past(c_idx)]) == ($past(shared_in) ? ST_SHR : ST_EXC))); // R2
    AST_SHARED_ONLY_ON_RD: assert property (@(posedge clk) disable iff (!rst_n)
        shared_out |-> (snp_valid && snp_cmd == CMD_RD)); // R3
    AST_WRITE_ENDS_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_write && cpu_ready) |=>
        (line_st_t'(st_all[$past(c_idx)]) == ST_MOD)); // R4
    AST_WB_BEFORE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && (bus_cmd == CMD_RD || bus_cmd == CMD_RDX)) |-> (c_st != ST_MOD)); // R7
    AST_FLUSH_DROPS_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        flush_out |=> (line_st_t'(st_all[$past(s_idx)]) != ST_MOD)); // R8
    AST_STALL_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |-> !cpu_ready); // R10
    AST_SNOOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> (!bus_req && !cpu_ready)); // R11
endmodule

// File: tb/test_mesi_line_ctrl.sv
// Self-checking bench: a behavioural line-state model drives the expected
// values; sweeps every start state against every snoop command.
module test_mesi_line_ctrl;
    import mesi_pkg::*;
    localparam int INDEX_W = 2;
    localparam int TAG_W   = 6;
    localparam int ADDR_W  = 8;
    localparam int LINES   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_valid = 1'b0, cpu_write = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic cpu_ready, bus_req, shared_out, flush_out;
    logic [1:0] bus_cmd;
    logic [ADDR_W-1:0] bus_addr;
    logic bus_gnt = 1'b0, shared_in = 1'b0, snp_valid = 1'b0;
    logic [1:0] snp_cmd = 2'd0;
    logic [ADDR_W-1:0] snp_addr = '0;

    int n_chk = 0, n_fail = 0;
    int m_st [LINES];
    logic [TAG_W-1:0] m_tag [LINES];

    always #4 clk = ~clk;

    mesi_line_ctrl #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) i_mesi_line_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
        .cpu_addr(cpu_addr), .cpu_ready(cpu_ready), .bus_req(bus_req),
        .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
        .shared_in(shared_in), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
        .snp_addr(snp_addr), .shared_out(shared_out), .flush_out(flush_out)
    );

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Processor access with a grant delay of gd cycles per transaction.
    task automatic do_cpu(input bit wr, input logic [ADDR_W-1:0] a, input bit shin, input int gd);
        int idx = int'(a[INDEX_W-1:0]);
        logic [TAG_W-1:0] tg = a[ADDR_W-1:INDEX_W];
        bit hit = (m_st[idx] != 0) && (m_tag[idx] == tg);
        int ntx = 0;
        logic [1:0] cmds [2];
        logic [ADDR_W-1:0] adrs [2];
        string rq;
        if (hit) begin
            rq = wr ? ((m_st[idx] == 1) ? "R5" : "R4") : "R12";
            if (wr && m_st[idx] == 1) begin cmds[0] = 2'd2; adrs[0] = a; ntx = 1; end
        end else begin
            rq = wr ? "R6" : "R2";
            if (m_st[idx] == 3) begin cmds[0] = 2'd3; adrs[0] = {m_tag[idx], a[INDEX_W-1:0]}; ntx = 1; end
            cmds[ntx] = wr ? 2'd1 : 2'd0; adrs[ntx] = a; ntx++;
        end
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; bus_gnt = 1'b0; shared_in = 1'b0;
        if (ntx == 0) begin
            #1;
            chk(rq, "ready", cpu_ready, 1);
            chk(rq, "bus_req", bus_req, 0);
            @(negedge clk);
        end else begin
            for (int k = 0; k < ntx; k++) begin
                string rk = (cmds[k] == 2'd3) ? "R7" : rq;
                for (int d = 0; d < gd; d++) begin
                    #1;
                    chk("R10", "stall bus_req", bus_req, 1);
                    chk("R10", "stall ready", cpu_ready, 0);
                    chk("R10", "stall cmd", bus_cmd, cmds[k]);
                    @(negedge clk);
                end
                bus_gnt = 1'b1; shared_in = shin;
                #1;
                chk(rk, "cmd", bus_cmd, cmds[k]);
                chk(rk, "addr", bus_addr, adrs[k]);
                chk("R10", "ready at grant", cpu_ready, (k == ntx - 1));
                @(negedge clk);
                bus_gnt = 1'b0; shared_in = 1'b0;
            end
        end
        cpu_valid = 1'b0;
        if (wr) begin m_st[idx] = 3; m_tag[idx] = tg; end
        else if (!hit) begin m_st[idx] = shin ? 1 : 2; m_tag[idx] = tg; end
    endtask

    // Snooped transaction, optionally with a local store held pending.
    task automatic do_snoop(input logic [1:0] cmd, input logic [ADDR_W-1:0] a, input bit hold);
        int idx = int'(a[INDEX_W-1:0]);
        bit hit = (m_st[idx] != 0) && (m_tag[idx] == a[ADDR_W-1:INDEX_W]);
        string rq = (cmd == 2'd0) ? "R9" : ((cmd == 2'd3) ? "R12" : "R8");
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a;
        if (hold) begin cpu_valid = 1'b1; cpu_write = 1'b1; cpu_addr = a ^ 8'h08; bus_gnt = 1'b1; end
        #1;
        chk("R3", "shared_out", shared_out, hit && cmd == 2'd0);
        chk(rq, "flush", flush_out, hit && m_st[idx] == 3 && cmd <= 2'd1);
        if (hold) begin
            chk("R11", "bus_req", bus_req, 0);
            chk("R11", "ready", cpu_ready, 0);
        end
        @(negedge clk);
        snp_valid = 1'b0; cpu_valid = 1'b0; bus_gnt = 1'b0;
        if (hit) begin
            if (cmd == 2'd0) m_st[idx] = 1;
            else if (cmd != 2'd3) m_st[idx] = 0;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_tag[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1", "ready idle", cpu_ready, 0);
        chk("R1", "bus_req idle", bus_req, 0);
        chk("R1", "shared_out idle", shared_out, 0);
        chk("R1", "flush idle", flush_out, 0);
        // R1: every line starts invalid, so a read on each index misses.
        for (int i = 0; i < LINES; i++) do_cpu(1'b0, {6'd9, 2'(i)}, i[0], i % 3);
        // R4 R12: silent upgrade of an exclusive line, then hits.
        do_cpu(1'b0, {6'd9, 2'd0}, 1'b0, 0);
        do_cpu(1'b1, {6'd9, 2'd0}, 1'b0, 0);
        do_cpu(1'b1, {6'd9, 2'd0}, 1'b0, 0);
        // R7: dirty victim written back, then clean victim dropped.
        do_cpu(1'b0, {6'd21, 2'd0}, 1'b0, 2);
        do_cpu(1'b1, {6'd22, 2'd1}, 1'b0, 1);
        // Sweep: start state x snoop command x tag hit/miss.
        for (int s = 0; s < 4; s++)
            for (int c = 0; c < 4; c++)
                for (int v = 0; v < 2; v++) begin
                    logic [ADDR_W-1:0] a = {6'(s * 8 + c * 2 + v + 1), 2'((s + c) % 4)};
                    logic [ADDR_W-1:0] b = a ^ 8'h40;
                    do_snoop(2'd1, a, 1'b0);
                    if (s == 1) do_cpu(1'b0, a, 1'b1, v);
                    if (s == 2) do_cpu(1'b0, a, 1'b0, v);
                    if (s == 3) do_cpu(1'b1, a, 1'b0, v + 1);
                    do_snoop(2'(c), v ? a : (a ^ 8'h04), 1'((c + v) % 2));
                    do_snoop(2'd0, a, 1'b1);
                    do_cpu(1'b1, a, 1'b0, (s + c) % 3);
                    do_cpu(1'b0, b, 1'(v), c % 2);
                end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule